// File: doc/BRIEF.md
# LCD Segment Drive Level Generator

This block decides, for every segment line of a multiplexed passive LCD, which drive voltage the pad should present during the current common phase. It runs its own phase and frame sequencer. On each phase step it selects, for every segment, the pixel bit that belongs to the common now active. It then combines that bit with the odd/even frame polarity and the bias mode to produce a 3-bit level code. The level alternates polarity from frame to frame, so the average DC across each pixel is zero.

The duty setting, the bias setting and the pixel image are captured only at the start of a frame. Changes made by software during a frame therefore take effect cleanly at the next frame. Clearing the enable parks every segment at ground and returns the sequencer to its start state. Analog level generation and the pads lie outside this block.

Top module: `lcd_seg_level_gen`

## Requirements
- R1: While `enable` is low, the edge after it is sampled low leaves every segment code at 0 (VSS), `com_idx` at 0 and `odd_frame` at 1. Reset gives the same state.
- R2: At the first clock edge with `enable` high after it was low, the block starts a frame. `com_idx` becomes 0, `odd_frame` becomes 1, and the segment codes for common 0 are loaded at that same edge. Any `phase_tick` in that cycle is ignored.
- R3: While the block runs, each clock edge with `phase_tick` high advances `com_idx` by one. After the last phase it wraps to 0. The frame length comes from `duty_sel`: 0 gives 1 phase, 1 gives 2, 2 gives 3, 3 gives 4, and 4 to 7 give 8.
- R4: `odd_frame` inverts at each wrap from the last phase to phase 0.
- R5: A segment whose selected pixel bit is 1 gets code 0 (VSS) in an odd frame and code 6 (VLCD) in an even frame.
- R6: With `bias_sel`=0 (half bias), a segment whose pixel bit is 0 gets code 6 in an odd frame and code 0 in an even frame.
- R7: With `bias_sel`=1 (third bias), a segment whose pixel bit is 0 gets code 4 (2/3 VLCD) in an odd frame and code 2 (1/3 VLCD) in an even frame.
- R8: With `bias_sel`=2 or 3 (quarter bias), a segment whose pixel bit is 0 gets code 3 (half VLCD) in both frame polarities.
- R9: In phase c, segment s uses pixel bit `pix_ram[c*NUM_SEG+s]`.
- R10: The values of `duty_sel`, `bias_sel` and `pix_ram` are taken only at a frame start, meaning R2 or a wrap. Changes at any other time have no effect on the outputs until the next frame start.
- R11: While running, the segment codes, `com_idx` and `odd_frame` hold their values on any edge without `phase_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low forces all segments to VSS |
| phase_tick | input | 1 | One-cycle pulse that steps to the next phase |
| duty_sel | input | 3 | Phases per frame code (0..4 gives 1,2,3,4,8; 5..7 gives 8) |
| bias_sel | input | 2 | 0 = 1/2, 1 = 1/3, 2 or 3 = 1/4 bias |
| pix_ram | input | 8*NUM_SEG | Pixel image; bit c*NUM_SEG+s is segment s under common c |
| com_idx | output | 3 | Active common (phase) index |
| odd_frame | output | 1 | 1 in odd frames, 0 in even frames |
| seg_lvl | output | 3*NUM_SEG | Level code per segment, segment s at bits 3s+2..3s |

## Verification
A wrong phase count or a missed wrap shows on `com_idx` at the first step that should have wrapped. From then on every segment reads pixels from the wrong common. An inverted frame flag shows on every segment at the very next load, because active pixels then produce VLCD instead of VSS. A shadow register that updates too early or too late shows at the next phase step, when a setting changed in mid-frame reaches the outputs one frame early or late. The reference model therefore compares every port on every clock, and mid-frame changes are driven on purpose.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

  localparam int PH_W    = 3;
  localparam int NUM_COM = 1 << PH_W;
  localparam int LVL_W   = 3;

  typedef enum logic [LVL_W-1:0] {
    LVL_VSS  = 3'd0,
    LVL_Q1   = 3'd1,
    LVL_T1   = 3'd2,
    LVL_HALF = 3'd3,
    LVL_T2   = 3'd4,
    LVL_Q3   = 3'd5,
    LVL_VLCD = 3'd6
  } lvl_e;

  typedef enum logic [1:0] {
    BIAS_HALF  = 2'd0,
    BIAS_THIRD = 2'd1,
    BIAS_QUART = 2'd2,
    BIAS_QALT  = 2'd3
  } bias_e;

  // Number of phases in a frame for a duty code.
  function automatic logic [PH_W:0] duty_len(input logic [2:0] code);
    case (code)
      3'd0:    duty_len = 4'd1;
      3'd1:    duty_len = 4'd2;
      3'd2:    duty_len = 4'd3;
      3'd3:    duty_len = 4'd4;
      default: duty_len = 4'd8;
    endcase
  endfunction

  // Drive level for one segment given its pixel, polarity and bias.
  function automatic lvl_e seg_level(input logic pix, input logic odd,
                                     input logic [1:0] bias);
    if (pix) begin
      seg_level = odd ? LVL_VSS : LVL_VLCD;
    end else begin
      case (bias_e'(bias))
        BIAS_HALF:  seg_level = odd ? LVL_VLCD : LVL_VSS;
        BIAS_THIRD: seg_level = odd ? LVL_T2 : LVL_T1;
        default:    seg_level = LVL_HALF;
      endcase
    end
  endfunction

endpackage

// File: rtl/lcd_seg_seq.sv
module lcd_seg_seq
  import lcd_seg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            phase_tick,
  input  logic [2:0]      duty_cur,
  output logic [PH_W-1:0] com_idx,
  output logic            odd_frame,
  output logic [PH_W-1:0] nxt_phase,
  output logic            nxt_odd,
  output logic            frame_start,
  output logic            load_lvl
);

  logic running;
  logic last_phase;
  logic step;

  assign last_phase  = ({1'b0, com_idx} == (duty_len(duty_cur) - 4'd1));
  assign step        = enable & running & phase_tick;
  assign frame_start = (enable & ~running) | (step & last_phase);
  assign load_lvl    = (enable & ~running) | step;

  always_comb begin
    if (!running) begin
      nxt_phase = '0;
      nxt_odd   = 1'b1;
    end else if (last_phase) begin
      nxt_phase = '0;
      nxt_odd   = ~odd_frame;
    end else begin
      nxt_phase = com_idx + 1'b1;
      nxt_odd   = odd_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      com_idx   <= '0;
      odd_frame <= 1'b1;
    end else if (!enable) begin
      running   <= 1'b0;
      com_idx   <= '0;
      odd_frame <= 1'b1;
    end else if (load_lvl) begin
      running   <= 1'b1;
      com_idx   <= nxt_phase;
      odd_frame <= nxt_odd;
    end
  end

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last_phase) |=> (com_idx == $past(com_idx) + 1'b1));

  // R3
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_phase) |=> (com_idx == '0));

  // R4
  frame_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_phase) |=> (odd_frame != $past(odd_frame)));

  // R2
  start_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !running) |=> (com_idx == '0 && odd_frame));

endmodule

// File: rtl/lcd_seg_shadow.sv
module lcd_seg_shadow
  import lcd_seg_pkg::*;
#(
  parameter int NUM_SEG = 44,
  localparam int RAM_W  = NUM_COM * NUM_SEG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [2:0]       duty_in,
  input  logic [1:0]       bias_in,
  input  logic [RAM_W-1:0] ram_in,
  output logic [2:0]       duty_cur,
  output logic [1:0]       bias_eff,
  output logic [RAM_W-1:0] ram_eff
);

  logic [1:0]       bias_q;
  logic [RAM_W-1:0] ram_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_cur <= '0;
      bias_q   <= '0;
      ram_q    <= '0;
    end else if (frame_start) begin
      duty_cur <= duty_in;
      bias_q   <= bias_in;
      ram_q    <= ram_in;
    end
  end

  // The first phase of a frame already uses the values being captured.
  assign bias_eff = frame_start ? bias_in : bias_q;
  assign ram_eff  = frame_start ? ram_in  : ram_q;

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(duty_cur) && $stable(bias_q) && $stable(ram_q)));

endmodule

// File: rtl/lcd_seg_lane.sv
module lcd_seg_lane
  import lcd_seg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               load_lvl,
  input  logic [NUM_COM-1:0] pix_row,
  input  logic [PH_W-1:0]    phase,
  input  logic               odd,
  input  logic [1:0]         bias,
  output logic [LVL_W-1:0]   lvl_o
);

  lvl_e lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_VSS;
    end else if (!enable) begin
      lvl_q <= LVL_VSS;
    end else if (load_lvl) begin
      lvl_q <= seg_level(pix_row[phase], odd, bias);
    end
  end

  assign lvl_o = lvl_q;

  // R1
  off_vss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (lvl_q == LVL_VSS));

  // R11
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !load_lvl) |=> $stable(lvl_q));

  // R5 R6 R7 R8: only the five segment levels can appear
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (lvl_q != LVL_Q1 && lvl_q != LVL_Q3 && lvl_q != 3'd7));

endmodule

// File: rtl/lcd_seg_level_gen.sv
module lcd_seg_level_gen
  import lcd_seg_pkg::*;
#(
  parameter int NUM_SEG = 44,
  localparam int RAM_W  = NUM_COM * NUM_SEG,
  localparam int OUT_W  = LVL_W * NUM_SEG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             phase_tick,
  input  logic [2:0]       duty_sel,
  input  logic [1:0]       bias_sel,
  input  logic [RAM_W-1:0] pix_ram,
  output logic [PH_W-1:0]  com_idx,
  output logic             odd_frame,
  output logic [OUT_W-1:0] seg_lvl
);

  logic [2:0]       duty_cur;
  logic [1:0]       bias_eff;
  logic [RAM_W-1:0] ram_eff;
  logic [PH_W-1:0]  nxt_phase;
  logic             nxt_odd;
  logic             frame_start;
  logic             load_lvl;

  lcd_seg_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .phase_tick  (phase_tick),
    .duty_cur    (duty_cur),
    .com_idx     (com_idx),
    .odd_frame   (odd_frame),
    .nxt_phase   (nxt_phase),
    .nxt_odd     (nxt_odd),
    .frame_start (frame_start),
    .load_lvl    (load_lvl)
  );

  lcd_seg_shadow #(.NUM_SEG(NUM_SEG)) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .duty_in     (duty_sel),
    .bias_in     (bias_sel),
    .ram_in      (pix_ram),
    .duty_cur    (duty_cur),
    .bias_eff    (bias_eff),
    .ram_eff     (ram_eff)
  );

  // R9: segment s under common c reads bit c*NUM_SEG+s
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [NUM_COM-1:0] row;
    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
      assign row[c] = ram_eff[c*NUM_SEG + s];
    end
    lcd_seg_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .load_lvl (load_lvl),
      .pix_row  (row),
      .phase    (nxt_phase),
      .odd      (nxt_odd),
      .bias     (bias_eff),
      .lvl_o    (seg_lvl[s*LVL_W +: LVL_W])
    );
  end

  // R1
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (com_idx == '0 && odd_frame && seg_lvl == '0));

endmodule

// File: tb/lcd_seg_level_gen_test.sv
module lcd_seg_level_gen_test;

  localparam int NSEG = 44;
  localparam int RW   = 8 * NSEG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic phase_tick = 1'b0;
  logic [2:0] duty_sel = '0;
  logic [1:0] bias_sel = '0;
  logic [RW-1:0] pix_ram = '0;
  logic [2:0] com_idx;
  logic odd_frame;
  logic [3*NSEG-1:0] seg_lvl;

  lcd_seg_level_gen #(.NUM_SEG(NSEG)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .phase_tick(phase_tick),
    .duty_sel(duty_sel), .bias_sel(bias_sel), .pix_ram(pix_ram),
    .com_idx(com_idx), .odd_frame(odd_frame), .seg_lvl(seg_lvl)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string scen = "R1";
  int frames_len[8] = '{1, 2, 3, 4, 8, 8, 8, 8};

  // Reference model state
  bit m_run;
  int m_ph;
  bit m_odd;
  int m_duty, m_bias;
  bit [RW-1:0] m_ram;
  int m_lvl[NSEG];
  bit m_pix[NSEG];

  function automatic int ref_level(bit pix, bit odd, int bias);
    if (pix) return odd ? 0 : 6;
    if (bias == 0) return odd ? 6 : 0;
    if (bias == 1) return odd ? 4 : 2;
    return 3;
  endfunction

  task automatic reload();
    for (int s = 0; s < NSEG; s++) begin
      m_pix[s] = m_ram[m_ph * NSEG + s];
      m_lvl[s] = ref_level(m_pix[s], m_odd, m_bias);
    end
  endtask

  task automatic take_settings();
    m_duty = int'(duty_sel);
    m_bias = int'(bias_sel);
    m_ram  = pix_ram;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !enable) begin
      m_run = 0; m_ph = 0; m_odd = 1;
      for (int s = 0; s < NSEG; s++) begin m_lvl[s] = 0; m_pix[s] = 0; end
    end else if (!m_run) begin
      m_run = 1; m_ph = 0; m_odd = 1;
      take_settings();
      reload();
    end else if (phase_tick) begin
      if (m_ph + 1 >= frames_len[m_duty]) begin
        m_ph = 0; m_odd = !m_odd;
        take_settings();
      end else begin
        m_ph = m_ph + 1;
      end
      reload();
    end
  end

  function automatic string seg_tag(int s);
    if (!m_run) return "R1";
    if (m_pix[s]) return "R5";
    if (m_bias == 0) return "R6";
    if (m_bias == 1) return "R7";
    return "R8";
  endfunction

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (int'(com_idx) != m_ph) begin
      errors++;
      $display("FAIL R3/%s com_idx got %0d exp %0d", scen, com_idx, m_ph);
    end
    checks++;
    if (odd_frame != m_odd) begin
      errors++;
      $display("FAIL R4/%s odd_frame got %0d exp %0d", scen, odd_frame, m_odd);
    end
    checks++;
    for (int s = 0; s < NSEG; s++) begin
      if (int'(seg_lvl[3*s +: 3]) != m_lvl[s]) begin
        errors++;
        $display("FAIL %s/%s seg %0d got %0d exp %0d", seg_tag(s), scen, s,
                 seg_lvl[3*s +: 3], m_lvl[s]);
        break;
      end
    end
  end

  task automatic rand_ram();
    for (int i = 0; i < RW; i++) pix_ram[i] = 1'($urandom);
  endtask

  task automatic run(int n, int tick_pct, bit churn);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      phase_tick = (($urandom % 100) < tick_pct);
      if (churn) begin
        duty_sel = 3'($urandom);
        bias_sel = 2'($urandom);
        pix_ram[$urandom % RW] = 1'($urandom);
      end
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset and disabled state
    scen = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(4, 50, 0);

    // R2: start from idle, quarter duty, third bias
    scen = "R2";
    @(negedge clk);
    duty_sel = 3'd3; bias_sel = 2'd1; rand_ram();
    phase_tick = 1'b1;  // ignored on the start edge
    enable = 1'b1;
    run(200, 50, 0);

    // R9: every duty and bias code, fresh image each time (covers R3-R8)
    scen = "R9";
    for (int d = 0; d < 8; d++) begin
      for (int b = 0; b < 4; b++) begin
        @(negedge clk);
        enable = 1'b0;
        run(1, 50, 0);
        duty_sel = 3'(d); bias_sel = 2'(b); rand_ram();
        enable = 1'b1;
        run(60, 60, 0);
      end
    end

    // R10: settings and image change in mid-frame
    scen = "R10";
    run(600, 40, 1);

    // R11: no ticks, inputs churn, outputs must hold
    scen = "R11";
    run(40, 0, 1);

    // R1: disable while running with ticks present
    scen = "R1";
    @(negedge clk);
    enable = 1'b0;
    run(10, 80, 1);
    @(negedge clk);
    enable = 1'b1;
    scen = "R2";
    run(100, 50, 0);

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule